// File: doc/BRIEF.md
# One-Hot Controller with Illegal-State Recovery

This block is a four-state sequencing controller. It keeps its state in a 4-bit one-hot register. The four states are idle, running, paused and finished. A start strobe `go` moves it from idle to running. A completion strobe `fin` moves it from running to finished. Finished then returns to idle by itself, and paused resumes running by itself.

Only four of the sixteen patterns the register can hold are legal. A population count of the state bits runs every cycle. If the count is not exactly one, the next clock puts the machine back in idle, whatever the other inputs are. One cycle later a registered flag reports the event. The check and the recovery are plain RTL and do not rely on any synthesis setting.

A test-only load port can overwrite the register with any 4-bit value for one cycle. This lets a bench imitate an upset. It can also place the machine in the paused state, which the normal transitions never reach.

Top module: `onehot_guard_fsm`

## Requirements
- R1: While `rst` is high at a rising edge, the register loads 4'b0001 (idle) and `illegal_flag` is cleared. `rst` has priority over every other input, including `inject_en`.
- R2: In idle (4'b0001) with `go` high, the next state is running (4'b0010). With `go` low, the machine stays in idle.
- R3: In running (4'b0010) with `fin` high, the next state is finished (4'b1000). With `fin` low, the machine stays in running.
- R4: In paused (4'b0100), the next state is running (4'b0010), whatever `go` and `fin` are.
- R5: In finished (4'b1000), the next state is idle (4'b0001), whatever `go` and `fin` are.
- R6: When `inject_en` is high and `rst` is low at a rising edge, the register takes `inject_val`, overriding all next-state logic.
- R7: When the register holds a pattern with zero bits set or with two or more bits set, and `inject_en` and `rst` are low, the next state is idle (4'b0001), whatever `go` and `fin` are.
- R8: After each rising edge where `rst` is low, `illegal_flag` equals 1 exactly when the state held just before that edge was not one-hot. A single illegal pattern therefore gives a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Start request, used in idle |
| fin | input | 1 | Completion request, used in running |
| inject_en | input | 1 | Test-only: load `inject_val` into the state register |
| inject_val | input | 4 | Test-only pattern to load |
| state_out | output | 4 | Current one-hot state: bit0 idle, bit1 running, bit2 paused, bit3 finished |
| illegal_flag | output | 1 | Registered pulse: the previous state was not one-hot |

## Verification
The transition assertions assume that `inject_en` is low in the cycle they check, because an injection legitimately overrides every rule. The stimulus therefore separates injection cycles from the observation cycles that follow them. The flag assertion assumes the cycle before it was not in reset, so the stimulus holds `rst` across whole cycles. All sixteen register patterns are injected in turn. Each one is followed by a free-running cycle with `go` and `fin` both high, so the recovery rule is checked against inputs that would otherwise cause a transition.

// File: rtl/onehot_guard_fsm.sv
module onehot_guard_fsm (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic       fin,
  input  logic       inject_en,
  input  logic [3:0] inject_val,
  output logic [3:0] state_out,
  output logic       illegal_flag
);
  localparam int          NB       = 4;
  localparam logic [NB-1:0] S_IDLE  = 4'b0001;
  localparam logic [NB-1:0] S_RUN   = 4'b0010;
  localparam logic [NB-1:0] S_PAUSE = 4'b0100;
  localparam logic [NB-1:0] S_DONE  = 4'b1000;

  logic [NB-1:0] st_q, st_d;
  logic [2:0]    hot_cnt;
  logic          legal;
  logic          flag_q;

  always_comb begin
    hot_cnt = '0;
    for (int i = 0; i < NB; i++) hot_cnt = hot_cnt + {2'b00, st_q[i]};
  end

  assign legal = (hot_cnt == 3'd1);

  always_comb begin
    st_d = st_q;
    if (!legal) st_d = S_IDLE;
    else if (st_q[0]) st_d = go  ? S_RUN  : S_IDLE;
    else if (st_q[1]) st_d = fin ? S_DONE : S_RUN;
    else if (st_q[2]) st_d = S_RUN;
    else              st_d = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      flag_q <= 1'b0;
    end else begin
      st_q   <= inject_en ? inject_val : st_d;
      flag_q <= !legal;
    end
  end

  assign state_out    = st_q;
  assign illegal_flag = flag_q;
endmodule

module onehot_guard_fsm_chk (
  input logic       clk,
  input logic       rst,
  input logic       go,
  input logic       fin,
  input logic       inject_en,
  input logic [3:0] inject_val,
  input logic [3:0] state_out,
  input logic       illegal_flag
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (state_out == 4'b0001 && !illegal_flag));

  a_r2_go: assert property (@(posedge clk) disable iff (rst)
    (!inject_en && state_out == 4'b0001 && go) |=> state_out == 4'b0010);

  a_r3_fin: assert property (@(posedge clk) disable iff (rst)
    (!inject_en && state_out == 4'b0010 && fin) |=> state_out == 4'b1000);

  a_r4_pause_resume: assert property (@(posedge clk) disable iff (rst)
    (!inject_en && state_out == 4'b0100) |=> state_out == 4'b0010);

  a_r5_done_home: assert property (@(posedge clk) disable iff (rst)
    (!inject_en && state_out == 4'b1000) |=> state_out == 4'b0001);

  a_r6_inject_load: assert property (@(posedge clk) disable iff (rst)
    inject_en |=> state_out == $past(inject_val));

  a_r7_recover: assert property (@(posedge clk) disable iff (rst)
    (!inject_en && $countones(state_out) != 1) |=> state_out == 4'b0001);

  a_r8_flag_pulse: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> illegal_flag == ($countones($past(state_out)) != 1));
endmodule

bind onehot_guard_fsm onehot_guard_fsm_chk u_chk (
  .clk(clk), .rst(rst), .go(go), .fin(fin), .inject_en(inject_en),
  .inject_val(inject_val), .state_out(state_out), .illegal_flag(illegal_flag)
);

// File: tb/test_onehot_guard_fsm.sv
module test_onehot_guard_fsm;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0, fin = 1'b0, inject_en = 1'b0;
  logic [3:0] inject_val = 4'b0000;
  logic [3:0] state_out;
  logic       illegal_flag;

  int checks = 0;
  int errors = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];
  logic [3:0] m_state = 4'b0001;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  onehot_guard_fsm i_onehot_guard_fsm (
    .clk(clk), .rst(rst), .go(go), .fin(fin), .inject_en(inject_en),
    .inject_val(inject_val), .state_out(state_out), .illegal_flag(illegal_flag)
  );

  function automatic int ones(input logic [3:0] v);
    int n = 0;
    for (int i = 0; i < 4; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic step(input logic r, input logic g, input logic f,
                      input logic ie, input logic [3:0] iv, input string tag);
    logic [3:0] nxt;
    logic       fl;
    @(negedge clk);
    rst = r; go = g; fin = f; inject_en = ie; inject_val = iv;
    fl = (ones(m_state) != 1);
    if (r) begin nxt = 4'b0001; fl = 1'b0; end
    else if (ie) nxt = iv;
    else if (ones(m_state) != 1) nxt = 4'b0001;
    else case (m_state)
      4'b0001: nxt = g ? 4'b0010 : 4'b0001;
      4'b0010: nxt = f ? 4'b1000 : 4'b0010;
      4'b0100: nxt = 4'b0010;
      default: nxt = 4'b0001;
    endcase
    m_state = nxt;
    exp_q.push_back({nxt, fl});
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({state_out, illegal_flag} !== e) begin
        errors++;
        $display("FAIL %s: state=%b flag=%b expected state=%b flag=%b",
                 t, state_out, illegal_flag, e[4:1], e[0]);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(1, 0, 0, 0, 4'b0000, "R1 reset");
    step(1, 1, 1, 1, 4'b0110, "R1 reset beats inject");
    step(0, 0, 1, 0, 4'b0000, "R2 idle hold");
    step(0, 1, 0, 0, 4'b0000, "R2 go");
    step(0, 1, 0, 0, 4'b0000, "R3 run hold");
    step(0, 0, 1, 0, 4'b0000, "R3 fin");
    step(0, 1, 1, 0, 4'b0000, "R5 done home");
    step(0, 0, 0, 1, 4'b0100, "R6 inject pause");
    step(0, 0, 0, 0, 4'b0000, "R4 pause resume");
    step(0, 0, 0, 1, 4'b0100, "R6 inject pause again");
    step(0, 1, 1, 0, 4'b0000, "R4 pause ignores go fin");
    step(0, 0, 0, 1, 4'b1000, "R6 inject done");
    step(0, 0, 0, 0, 4'b0000, "R5 done home after inject");
    for (int v = 0; v < 16; v++) begin
      step(0, 0, 0, 1, 4'(v), "R6 inject sweep");
      step(0, 1, 1, 0, 4'b0000, "R7 R8 next after sweep");
      step(0, 0, 0, 0, 4'b0000, "R8 flag single pulse");
    end
    step(0, 0, 0, 1, 4'b1111, "R6 inject all hot");
    step(0, 0, 0, 1, 4'b0000, "R8 flag zero hot back to back");
    step(0, 0, 0, 1, 4'b0101, "R8 flag stays on repeated upsets");
    step(0, 1, 1, 0, 4'b0000, "R7 recover multi hot");
    step(0, 1, 0, 0, 4'b0000, "R8 flag cleared, R2 go");
    step(0, 0, 0, 1, 4'b0011, "R6 inject while running");
    step(1, 0, 0, 0, 4'b0000, "R1 reset clears illegal");
    step(0, 0, 0, 0, 4'b0000, "R1 idle after reset");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule